// File: doc/BRIEF.md
# Rate-Limited Multi-Port Cell-Available Responder

This block stands in for a multi-port physical-layer device on the transmit side of a cell bus. The bus master places port addresses on a shared address bus. The responder answers, one cycle later, with a cell-available level for any of its own active ports. It then takes in 27-word cells written to whichever port the master selects. Each accepted word leaves the block tagged with the number of the port it was written to.

A port takes part only while it is bound to one of four rate generators. Each generator holds a cell period that caps the cell rate of every port bound to it. Every port has its own down-counter. The counter is reloaded from the bound generator's period when a cell starts on that port. The port reports space again only once its counter has drained and its cell is complete.

In the polled mode, one shared cell-available line is driven, and only in the cycle after an owned, bound address appears on the bus. In direct mode, each of the low four ports gets its own cell-available line, and those lines are driven continuously.

Top module: `phy_tx_clav_responder`

## Requirements
- R1: A port whose bind bit is low never answers a poll (clav_oe and clav stay 0), and words written after selecting it produce no out_valid.
- R2: In polled mode, clav[0] and clav_oe hold the answer for the address sampled at the previous clock edge. clav[3:1] are 0. Addresses at or above NPORTS (31 by default) are never answered.
- R3: Polling a bound port whose counter is zero and which is not receiving a cell gives clav_oe=1 and clav[0]=1.
- R4: When a cell starts on a port, that port's counter loads the bound generator's period P and then counts down by one per clock. The port answers 0 while its counter is nonzero or its cell is in progress. For P=40, a poll at the 40th edge after the start edge answers 0, and a poll at the 41st edge answers 1.
- R5: The period is shared per generator, but counters are per port. A second port on the same generator is unaffected by another port's cell. A port whose generator period is 0 answers 1 on the first poll after its cell ends.
- R6: A port is selected by the address present in the cycle before bus_enb_n falls. Words are taken only while bus_enb_n is 0, and a cell begins only with bus_soc=1. Raising bus_enb_n mid-cell pauses the cell, and the selection is kept until the 27th word.
- R7: Each accepted word appears one cycle later on out_valid, with out_data and out_port. out_sop marks word 1 and out_eop marks word 27.
- R8: In direct mode, clav[k] reflects whether port k can take a cell, clav_oe is 1, and lines of unbound ports stay 0.
- R9: During reset, clav, clav_oe and out_valid are 0 and all port counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| direct_mode | input | 1 | 1: one cell-available line per port; 0: polled shared line |
| port_bound | input | NPORTS | Per-port bind bit; only bound ports are active |
| port_gen | input | NPORTS*2 | Generator index per port, port p at bits [2p+1:2p] |
| gen_period | input | 4*PW | Cell period per generator, generator g at bits [g*PW +: PW] |
| bus_addr | input | AW | Port address from the bus master |
| bus_enb_n | input | 1 | Active-low write enable |
| bus_soc | input | 1 | Start-of-cell flag on the first word |
| bus_data | input | DW | Cell word |
| clav | output | NCLAV | Cell-available lines (bit 0 only in polled mode) |
| clav_oe | output | 1 | Drive enable for the cell-available output |
| out_valid | output | 1 | Accepted word valid |
| out_sop | output | 1 | First word of a cell |
| out_eop | output | 1 | Last word of a cell |
| out_port | output | AW | Port the word was written to |
| out_data | output | DW | Accepted word |

## Verification
The assertions assume the master holds direct_mode steady around a cell, and that it never restarts a cell on a port before the current cell has ended. They also assume the cell length is at least two words. The bench changes mode and bindings only while the bus is idle. It always sends a full 27-word cell with start-of-cell on the first word only. It parks the address bus on the unowned address 31 during data and pause cycles, so every poll the bench observes is one it placed deliberately.

// File: rtl/phy_tx_clav_responder.sv
module phy_tx_clav_responder #(
  parameter int NPORTS     = 31,
  parameter int AW         = 5,
  parameter int DW         = 16,
  parameter int NGEN       = 4,
  parameter int PW         = 8,
  parameter int NCLAV      = 4,
  parameter int CELL_WORDS = 27,
  localparam int GW = (NGEN > 1) ? $clog2(NGEN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 direct_mode,
  input  logic [NPORTS-1:0]    port_bound,
  input  logic [NPORTS*GW-1:0] port_gen,
  input  logic [NGEN*PW-1:0]   gen_period,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_enb_n,
  input  logic                 bus_soc,
  input  logic [DW-1:0]        bus_data,
  output logic [NCLAV-1:0]     clav,
  output logic                 clav_oe,
  output logic                 out_valid,
  output logic                 out_sop,
  output logic                 out_eop,
  output logic [AW-1:0]        out_port,
  output logic [DW-1:0]        out_data
);
  localparam int NA  = 2 ** AW;
  localparam int WCW = $clog2(CELL_WORDS);
  localparam logic [WCW-1:0] LAST_W = WCW'(CELL_WORDS - 1);

  logic [AW-1:0]  prev_addr_q, cur_port_q;
  logic           prev_enb_n_q, busy_q, sel_q;
  logic [WCW-1:0] wcnt_q;
  logic [NPORTS-1:0] ready;
  logic [NA-1:0]  bound_pad, ready_pad;

  assign bound_pad = NA'(port_bound);
  assign ready_pad = NA'(ready);

  wire           fall     = prev_enb_n_q && !bus_enb_n;
  wire           resel    = fall && !busy_q;
  wire [AW-1:0]  tgt_port = resel ? prev_addr_q : cur_port_q;
  wire           sel_now  = resel ? bound_pad[prev_addr_q] : sel_q;
  wire           word     = !bus_enb_n && sel_now;
  wire           start    = word && bus_soc;
  wire           mid      = word && !bus_soc && busy_q;
  wire           last     = mid && (wcnt_q == LAST_W);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [GW-1:0] gsel;
    logic [PW-1:0] period;
    logic [PW-1:0] cnt;
    assign gsel   = port_gen[p*GW +: GW];
    assign period = gen_period[gsel*PW +: PW];
    assign ready[p] = port_bound[p] && (cnt == '0) &&
                      !(busy_q && cur_port_q == AW'(p));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                            cnt <= '0;
      else if (start && tgt_port == AW'(p))  cnt <= period;
      else if (cnt != '0)                    cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_addr_q  <= '0;
      prev_enb_n_q <= 1'b0;
      cur_port_q   <= '0;
      sel_q        <= 1'b0;
      busy_q       <= 1'b0;
      wcnt_q       <= '0;
    end else begin
      prev_addr_q  <= bus_addr;
      prev_enb_n_q <= bus_enb_n;
      if (resel) begin
        cur_port_q <= prev_addr_q;
        sel_q      <= bound_pad[prev_addr_q];
      end
      if (start) begin
        busy_q <= 1'b1;
        wcnt_q <= WCW'(1);
      end else if (last) begin
        busy_q <= 1'b0;
        wcnt_q <= '0;
      end else if (mid) begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clav    <= '0;
      clav_oe <= 1'b0;
    end else if (direct_mode) begin
      clav    <= ready[NCLAV-1:0];
      clav_oe <= 1'b1;
    end else begin
      clav    <= NCLAV'(ready_pad[bus_addr]);
      clav_oe <= bound_pad[bus_addr];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_port  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= start || mid;
      out_sop   <= start;
      out_eop   <= last;
      if (start || mid) begin
        out_port <= tgt_port;
        out_data <= bus_data;
      end
    end
endmodule

// File: rtl/clav_resp_checker.sv
module clav_resp_checker #(
  parameter int NPORTS = 31,
  parameter int AW     = 5,
  parameter int NCLAV  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              direct_mode,
  input logic [NPORTS-1:0] port_bound,
  input logic [AW-1:0]     bus_addr,
  input logic [NCLAV-1:0]  clav,
  input logic              clav_oe,
  input logic              out_valid,
  input logic              out_sop,
  input logic              out_eop,
  input logic [AW-1:0]     out_port
);
  localparam int NA = 2 ** AW;
  logic [NA-1:0] bp;
  logic          addr_active;
  assign bp          = NA'(port_bound);
  assign addr_active = bp[bus_addr];

  a_r1_unbound_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !direct_mode && !addr_active |=> !clav_oe);

  a_r2_upper_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!direct_mode) |-> clav[NCLAV-1:1] == '0);

  a_r2_clav_driven: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!direct_mode) && clav[0] |-> clav_oe);

  a_r4_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    direct_mode && out_valid && out_sop && out_port == '0 |=> !clav[0]);

  a_r6_port_steady: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sop && $past(out_valid) |-> $stable(out_port));

  a_r7_marks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_sop, out_eop}));

  a_r7_marks_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sop || out_eop) |-> out_valid);
endmodule

bind phy_tx_clav_responder clav_resp_checker #(.NPORTS(NPORTS), .AW(AW), .NCLAV(NCLAV)) u_chk (
  .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode), .port_bound(port_bound),
  .bus_addr(bus_addr), .clav(clav), .clav_oe(clav_oe), .out_valid(out_valid),
  .out_sop(out_sop), .out_eop(out_eop), .out_port(out_port));

// File: tb/test_phy_tx_clav_responder.sv
`timescale 1ns/1ps
module test_phy_tx_clav_responder;
  localparam int NP = 31, AW = 5, DW = 16, PW = 8, CW = 27;

  logic clk = 0, rst_n = 0, direct_mode = 0;
  logic [NP-1:0]   port_bound = '0;
  logic [NP*2-1:0] port_gen = '0;
  logic [4*PW-1:0] gen_period;
  logic [AW-1:0]   bus_addr = 5'd31;
  logic bus_enb_n = 1, bus_soc = 0;
  logic [DW-1:0]   bus_data = '0;
  logic [3:0] clav;
  logic clav_oe, out_valid, out_sop, out_eop;
  logic [AW-1:0] out_port;
  logic [DW-1:0] out_data;

  int n_chk = 0, n_fail = 0;
  int mon_n, mon_sop, mon_eop, mon_eop_idx, mon_bad, mon_port;

  always #2 clk = ~clk;

  phy_tx_clav_responder i_phy_tx_clav_responder (
    .clk, .rst_n, .direct_mode, .port_bound, .port_gen, .gen_period,
    .bus_addr, .bus_enb_n, .bus_soc, .bus_data, .clav, .clav_oe,
    .out_valid, .out_sop, .out_eop, .out_port, .out_data);

  always @(negedge clk) if (rst_n && out_valid) begin
    if (out_sop) mon_sop++;
    if (out_eop) begin mon_eop++; mon_eop_idx = mon_n; end
    if (int'(out_port) != mon_port || out_data != {8'(mon_port), 8'(mon_n)}) mon_bad++;
    mon_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bind_port(input int p, input bit b, input int g);
    @(negedge clk);
    port_bound[p] = b;
    port_gen[2*p +: 2] = 2'(g);
  endtask

  task automatic poll(input int a, output bit oe, output logic [3:0] cl);
    @(negedge clk);
    bus_addr = 5'(a); bus_enb_n = 1; bus_soc = 0;
    @(posedge clk); #1;
    oe = clav_oe; cl = clav;
  endtask

  task automatic send_cell(input int p, input int pause_at, input int pause_len);
    mon_n = 0; mon_sop = 0; mon_eop = 0; mon_eop_idx = -1; mon_bad = 0; mon_port = p;
    @(negedge clk); bus_addr = 5'(p); bus_enb_n = 1; bus_soc = 0;
    for (int i = 0; i < CW; i++) begin
      if (i == pause_at)
        for (int k = 0; k < pause_len; k++) begin
          @(negedge clk); bus_enb_n = 1; bus_addr = 5'd31; bus_soc = 0;
        end
      @(negedge clk);
      bus_enb_n = 0; bus_addr = 5'd31; bus_soc = (i == 0);
      bus_data = {8'(p), 8'(i)};
    end
    @(negedge clk); bus_enb_n = 1; bus_addr = 5'd31; bus_soc = 0;
    #1;
  endtask

  task automatic check_cell(input string req, input int exp_words);
    chk(mon_n == exp_words, req, mon_n, exp_words);
    if (exp_words > 0) begin
      chk(mon_sop == 1, req, mon_sop, 1);
      chk(mon_eop == 1 && mon_eop_idx == CW - 1, req, mon_eop_idx, CW - 1);
      chk(mon_bad == 0, req, mon_bad, 0);
    end
  endtask

  task automatic t_reset;
    #1;
    chk(clav == 0 && clav_oe == 0 && out_valid == 0, "R9", {clav, clav_oe, out_valid}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_poll_basic;
    bit oe; logic [3:0] cl;
    poll(3, oe, cl);
    chk(oe && cl == 4'b0001, "R3", {cl, oe}, 3);
    poll(5, oe, cl);
    chk(!oe && cl == 0, "R1", {cl, oe}, 0);
    poll(31, oe, cl);
    chk(!oe && cl == 0, "R2", {cl, oe}, 0);
    poll(7, oe, cl);
    chk(oe && cl == 4'b0001, "R2", {cl, oe}, 3);
  endtask

  task automatic t_rate;
    bit oe; logic [3:0] cl;
    send_cell(3, -1, 0);
    check_cell("R7", CW);
    poll(12, oe, cl);
    chk(oe && cl[0], "R5", cl[0], 1);
    for (int i = 0; i < 16; i++) begin
      poll(3, oe, cl);
      chk(cl[0] == ((29 + i) >= 41), "R4", cl[0], int'((29 + i) >= 41));
    end
  endtask

  task automatic t_zero_period;
    bit oe; logic [3:0] cl;
    send_cell(7, -1, 0);
    poll(7, oe, cl);
    chk(oe && cl[0], "R5", cl[0], 1);
  endtask

  task automatic t_pause;
    send_cell(7, 10, 3);
    check_cell("R6", CW);
  endtask

  task automatic t_unbound_write;
    send_cell(5, -1, 0);
    check_cell("R1", 0);
  endtask

  task automatic t_direct;
    bit oe; logic [3:0] cl;
    bind_port(3, 0, 0);
    bind_port(7, 0, 0);
    bind_port(12, 0, 0);
    bind_port(0, 1, 2);
    @(negedge clk); direct_mode = 1;
    poll(31, oe, cl);
    chk(oe && cl == 4'b0001, "R8", {cl, oe}, 3);
    send_cell(0, -1, 0);
    check_cell("R7", CW);
    poll(31, oe, cl);
    chk(cl == 4'b0000, "R8", cl, 0);
    repeat (8) poll(31, oe, cl);
    chk(oe && cl == 4'b0001, "R8", {cl, oe}, 3);
    @(negedge clk); direct_mode = 0;
  endtask

  initial begin
    gen_period = {8'd5, 8'd30, 8'd0, 8'd40};
    t_reset;
    bind_port(3, 1, 0);
    bind_port(12, 1, 0);
    bind_port(7, 1, 1);
    t_poll_basic;
    t_rate;
    t_zero_period;
    t_pause;
    t_unbound_write;
    t_direct;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule